// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox Controller

Eleven agents share this controller to signal each other. Each agent owns a register page. A sender writes the identity bits of one or more targets into its trigger register. This raises the sender's bit in each target's status register, and the target's interrupt output follows whenever that bit is not masked. A target acknowledges by writing a 1 to its own status bit.

The sender sees which of its notifications are still unacknowledged through its observation register. That register is a live view of the receivers' status bits, so software can poll it until the receiver has finished. Masking uses two registers, one that only sets mask bits and one that only clears them, so that no read-modify-write is needed.

Access is through a single-cycle register port. A page select picks the agent, a word address picks the register, and reads are combinational.

Top module: `ipi_mbox`

## Requirements
- R1: `sel_i` selects agent page 0 to 10 and `addr_i` is the word address (byte offset divided by 4). Word 0 is trigger, 1 is observation, 4 is status, 5 is mask, 6 is enable and 7 is disable. Words 2 and 3, and pages 11 to 15, read as zero, and writes to them have no effect.
- R2: Agents 0 to 10 have fixed one-hot identity bits 0, 8, 9, 16, 17, 18, 19, 24, 25, 26 and 27 in every register.
- R3: A write to the trigger register of page L with identity bit R set makes bit L readable in the status register of page R from the next cycle.
- R4: The observation register of page L has bit R set exactly while the status register of page R has bit L set.
- R5: Writing 1 to a status bit clears it from the next cycle. Writing 0 leaves it unchanged.
- R6: Writing 1s to the disable register sets those mask bits, and writing 1s to the enable register clears them. The mask register reads the current mask.
- R7: `irq_o[L]` is high exactly when page L has a status bit set whose mask bit is clear.
- R8: After reset every status bit is 0, every defined mask bit is 1, and every `irq_o` bit is low.
- R9: Bits outside the eleven identity positions are ignored on write and read as zero.
- R10: The trigger, enable and disable registers always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 4 | Agent page select |
| addr_i | input | 3 | Register word address within the page |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| irq_o | output | 11 | Level interrupt, one per agent |

## Verification
The pending state is stored once, as one bit per sender and receiver pair. A corrupted bit therefore shows at three places in the same cycle: the receiver's status read, the sender's observation read and, once unmasked, the receiver's interrupt. The bench sweeps every sender and receiver pair through trigger, unmask, zero-write, acknowledge and re-mask. After each write it compares all 128 register words of the page space, plus all interrupts, against a bench model. A stuck bit, a mis-routed identity bit or a wrong offset is therefore reported in the cycle after the write that exposes it.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;
  localparam int unsigned NUM_AGENTS = 11;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned SEL_W      = 4;
  localparam int unsigned WADDR_W    = 3;

  localparam logic [WADDR_W-1:0] W_TRIG = 3'd0;
  localparam logic [WADDR_W-1:0] W_OBS  = 3'd1;
  localparam logic [WADDR_W-1:0] W_STAT = 3'd4;
  localparam logic [WADDR_W-1:0] W_MASK = 3'd5;
  localparam logic [WADDR_W-1:0] W_EN   = 3'd6;
  localparam logic [WADDR_W-1:0] W_DIS  = 3'd7;

  typedef logic [NUM_AGENTS-1:0] agent_vec_t;

  // identity bit of agent a: 0 | 8..9 | 16..19 | 24..27
  function automatic int unsigned id_bit(int unsigned a);
    if (a == 0)      return 0;
    else if (a < 3)  return a + 7;
    else if (a < 7)  return a + 13;
    else             return a + 17;
  endfunction

  function automatic agent_vec_t gather(logic [DATA_W-1:0] w);
    agent_vec_t v;
    for (int unsigned a = 0; a < NUM_AGENTS; a++) v[a] = w[id_bit(a)];
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] scatter(agent_vec_t v);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int unsigned a = 0; a < NUM_AGENTS; a++) w[id_bit(a)] = v[a];
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] defined_bits();
    agent_vec_t ones;
    ones = '1;
    return scatter(ones);
  endfunction
endpackage

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode
  import ipi_mbox_pkg::*;
(
  input  logic               we_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [WADDR_W-1:0] addr_i,
  output agent_vec_t         trig_o,
  output agent_vec_t         ack_o,
  output agent_vec_t         en_o,
  output agent_vec_t         dis_o
);
  for (genvar p = 0; p < NUM_AGENTS; p++) begin : g_page
    localparam logic [SEL_W-1:0] PAGE = SEL_W'(p);
    logic hit;
    assign hit       = we_i && (sel_i == PAGE);
    assign trig_o[p] = hit && (addr_i == W_TRIG);
    assign ack_o[p]  = hit && (addr_i == W_STAT);
    assign en_o[p]   = hit && (addr_i == W_EN);
    assign dis_o[p]  = hit && (addr_i == W_DIS);
  end
endmodule

// File: rtl/ipi_agent_row.sv
module ipi_agent_row
  import ipi_mbox_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  agent_vec_t set_i,
  input  agent_vec_t clr_i,
  input  agent_vec_t mask_set_i,
  input  agent_vec_t mask_clr_i,
  output agent_vec_t pend_o,
  output agent_vec_t mask_o,
  output logic       irq_o
);
  agent_vec_t pend_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= (pend_q & ~clr_i) | set_i;  // trigger beats acknowledge
      mask_q <= (mask_q | mask_set_i) & ~mask_clr_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & ~mask_q);
endmodule

// File: rtl/ipi_read_mux.sv
module ipi_read_mux
  import ipi_mbox_pkg::*;
(
  input  logic [SEL_W-1:0]                  sel_i,
  input  logic [WADDR_W-1:0]                addr_i,
  input  logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] pend_i,
  input  logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] mask_i,
  output logic [DATA_W-1:0]                 rdata_o
);
  agent_vec_t obs_v, stat_v, mask_v;
  logic       valid;

  always_comb begin
    obs_v  = '0;
    stat_v = '0;
    mask_v = '0;
    valid  = 1'b0;
    for (int unsigned p = 0; p < NUM_AGENTS; p++) begin
      if (sel_i == SEL_W'(p)) begin
        valid  = 1'b1;
        stat_v = pend_i[p];
        mask_v = mask_i[p];
        for (int unsigned r = 0; r < NUM_AGENTS; r++) obs_v[r] = pend_i[r][p];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (valid) begin
      unique case (addr_i)
        W_OBS:   rdata_o = scatter(obs_v);
        W_STAT:  rdata_o = scatter(stat_v);
        W_MASK:  rdata_o = scatter(mask_v);
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ipi_mbox.sv
module ipi_mbox
  import ipi_mbox_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [WADDR_W-1:0]    addr_i,
  input  logic                  we_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_AGENTS-1:0] irq_o
);
  agent_vec_t trig, ack, en, dis, wvec;
  logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] pend_q, mask_q;
  logic unused_wbits;

  assign wvec         = gather(wdata_i);
  assign unused_wbits = ^(wdata_i & ~defined_bits());

  ipi_wr_decode u_dec (
    .we_i   (we_i),
    .sel_i  (sel_i),
    .addr_i (addr_i),
    .trig_o (trig),
    .ack_o  (ack),
    .en_o   (en),
    .dis_o  (dis)
  );

  for (genvar r = 0; r < NUM_AGENTS; r++) begin : g_row
    agent_vec_t set_v;
    assign set_v = trig & {NUM_AGENTS{wvec[r]}};  // senders naming agent r
    ipi_agent_row u_row (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (set_v),
      .clr_i      (ack[r] ? wvec : '0),
      .mask_set_i (dis[r] ? wvec : '0),
      .mask_clr_i (en[r]  ? wvec : '0),
      .pend_o     (pend_q[r]),
      .mask_o     (mask_q[r]),
      .irq_o      (irq_o[r])
    );
  end

  ipi_read_mux u_rd (
    .sel_i   (sel_i),
    .addr_i  (addr_i),
    .pend_i  (pend_q),
    .mask_i  (mask_q),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/ipi_mbox_sva.sv
module ipi_mbox_sva
  import ipi_mbox_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [SEL_W-1:0]      sel_i,
  input logic [WADDR_W-1:0]    addr_i,
  input logic                  we_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [NUM_AGENTS-1:0] irq_o,
  input logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] pend_q,
  input logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] mask_q
);
  localparam logic [DATA_W-1:0] DEF = defined_bits();

  assert_reserved_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~DEF) == '0);

  assert_wo_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == W_TRIG || addr_i == W_EN || addr_i == W_DIS) |-> rdata_o == '0);

  assert_bad_page_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i >= SEL_W'(NUM_AGENTS)) |-> rdata_o == '0);

  for (genvar r = 0; r < NUM_AGENTS; r++) begin : g_r
    localparam logic [SEL_W-1:0] PR = SEL_W'(r);

    assert_irq_needs_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[r] |-> (pend_q[r] != '0));

    assert_masked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q[r] == '1) |-> !irq_o[r]);

    for (genvar l = 0; l < NUM_AGENTS; l++) begin : g_l
      localparam logic [SEL_W-1:0] PL = SEL_W'(l);

      assert_trig_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == PL && addr_i == W_TRIG && wdata_i[id_bit(r)]) |=> pend_q[r][l]);

      assert_pend_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_q[r][l]) |-> $past(we_i && sel_i == PL && addr_i == W_TRIG && wdata_i[id_bit(r)]));

      assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == PR && addr_i == W_STAT && wdata_i[id_bit(l)]) |=> !pend_q[r][l]);

      assert_dis_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == PR && addr_i == W_DIS && wdata_i[id_bit(l)]) |=> mask_q[r][l]);

      assert_en_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == PR && addr_i == W_EN && wdata_i[id_bit(l)]) |=> !mask_q[r][l]);
    end
  end
endmodule

bind ipi_mbox ipi_mbox_sva u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .pend_q  (pend_q),
  .mask_q  (mask_q)
);

// File: tb/ipi_mbox_tb.sv
`timescale 1ns/1ps
module ipi_mbox_tb;
  localparam int N = 11;
  localparam int ID [N] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};
  localparam logic [31:0] DEF  = 32'h0F0F_0301;
  localparam logic [31:0] JUNK = ~DEF & 32'hA5A5_5A5A;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  sel_i = '0;
  logic [2:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [N-1:0] irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit pend [N][N];   // [receiver][sender]
  bit msk  [N][N];

  always #2.5 clk_i = ~clk_i;

  ipi_mbox u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, int pg, int w);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s page %0d word %0d: actual %h expected %h", req, pg, w, act, exp);
    end
  endtask

  // compare every word of every page and all interrupts against the model
  task automatic check_all(string stag);
    for (int p = 0; p < 16; p++) begin
      for (int w = 0; w < 8; w++) begin
        logic [31:0] e;
        string t;
        e = '0;
        sel_i  = 4'(p);
        addr_i = 3'(w);
        #0.5;
        if (p >= N) t = "R1";
        else begin
          case (w)
            1: begin t = "R4"; for (int r = 0; r < N; r++) if (pend[r][p]) e[ID[r]] = 1'b1; end
            4: begin t = stag; for (int l = 0; l < N; l++) if (pend[p][l]) e[ID[l]] = 1'b1; end
            5: begin t = "R6"; for (int l = 0; l < N; l++) if (msk[p][l])  e[ID[l]] = 1'b1; end
            2, 3: t = "R1";
            default: t = "R10";
          endcase
        end
        chk(t, rdata_o, e, p, w);
        chk("R9", rdata_o & ~DEF, 32'h0, p, w);
      end
    end
    for (int r = 0; r < N; r++) begin
      bit e;
      e = 1'b0;
      for (int l = 0; l < N; l++) if (pend[r][l] && !msk[r][l]) e = 1'b1;
      chk("R7", 32'(irq_o[r]), 32'(e), r, 0);
    end
  endtask

  task automatic op(int p, int w, logic [31:0] d, string stag);
    @(negedge clk_i);
    sel_i = 4'(p); addr_i = 3'(w); wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (p < N) begin
      for (int a = 0; a < N; a++) begin
        if (d[ID[a]]) begin
          case (w)
            0: pend[a][p] = 1'b1;
            4: pend[p][a] = 1'b0;
            6: msk[p][a]  = 1'b0;
            7: msk[p][a]  = 1'b1;
            default: ;
          endcase
        end
      end
    end
    check_all(stag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < N; r++) for (int l = 0; l < N; l++) begin pend[r][l] = 0; msk[r][l] = 1; end
    repeat (3) @(negedge clk_i);
    check_all("R8");   // state while reset held
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R8");

    // every sender/receiver pair: R2 mapping, R3 trigger, R5 ack, R6 mask
    for (int l = 0; l < N; l++) begin
      for (int r = 0; r < N; r++) begin
        op(l, 0, (32'h1 << ID[r]) | JUNK, "R3");
        op(r, 6, (32'h1 << ID[l]) | JUNK, "R2");
        op(r, 4, JUNK, "R5");
        op(r, 4, 32'h1 << ID[l], "R5");
        op(r, 7, 32'h1 << ID[l], "R6");
      end
    end

    // broadcast from every sender, unmask everything
    for (int l = 0; l < N; l++) op(l, 0, 32'hFFFF_FFFF, "R3");
    for (int r = 0; r < N; r++) op(r, 6, 32'hFFFF_FFFF, "R6");
    // R1: out-of-range pages and unused words change nothing
    for (int p = N; p < 16; p++) begin
      op(p, 4, 32'hFFFF_FFFF, "R1");
      op(p, 7, 32'hFFFF_FFFF, "R1");
    end
    op(3, 2, 32'hFFFF_FFFF, "R1");
    op(3, 3, 32'hFFFF_FFFF, "R1");
    // partial acknowledges and partial masking
    for (int r = 0; r < N; r++) op(r, 4, 32'h0A0A_0200 | 32'h1, "R5");
    for (int r = 0; r < N; r += 2) op(r, 7, DEF, "R6");
    for (int r = 1; r < N; r += 2) op(r, 4, DEF, "R5");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule